// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block sequences word addresses for synchronous burst reads on the memory side. After reset it is in asynchronous mode and ignores the address strobe. A configuration write with the burst-enable bit set switches it into synchronous mode. The same write also sets the address ordering, the wrap length and the initial latency.

A burst begins on the rising clock edge at which chip-enable and the address strobe are both low. The block captures the start address on that edge. After the configured number of clock cycles it presents the start word. It then presents one new word on each rising edge until chip-enable rises or a new strobe restarts it.

There are three orderings:
- Linear wrap within an aligned block.
- Interleaved wrap within an aligned block.
- Continuous, which walks the whole array and wraps from the top address to zero.

The block outputs the current word address and a valid flag. The word read from a small internal array at that address is also output.

Top module: `burst_read_seq`

## Requirements
- R1: During and directly after reset, `rd_valid` is 0 and `word_addr` is 0. The configuration resets to asynchronous mode, linear order, 4-word wrap and a latency of `DEF_LAT` cycles.
- R2: While burst mode is disabled, strobes are ignored and `rd_valid` stays 0.
- R3: A clock edge with `cfg_we` high loads all configuration fields. `cfg_sync_en`=1 enables burst mode. `cfg_mode` selects the order: 0 is linear, 1 is interleaved, 2 or 3 is continuous. `cfg_wrap` selects the block size: 0 is 4 words, 1 is 8, 2 is 16 and 3 is 32.
- R4: The start address is captured on an edge with `chip_en_n`=0, `addr_strobe_n`=0 and burst mode enabled. With latency L, `rd_valid` first rises at the L-th rising edge after the capture edge, and `word_addr` then equals the start address. A latency of 0 behaves as 1.
- R5: Once `rd_valid` is high, it stays high and the address advances on every edge while chip-enable stays low and no strobe arrives.
- R6: In linear order, word k of the burst has address base + ((s + k) mod B). Here B is the block size, s is the start offset within the block, and base is the start address with its low log2(B) bits cleared.
- R7: In interleaved order, word k of the burst has address base + (s XOR (k mod B)).
- R8: In continuous order, each word's address is one more than the previous one, modulo 2^ADDR_W, so the burst wraps from the top address to 0.
- R9: An edge with `chip_en_n`=1 ends the burst. `rd_valid` is 0 after that edge, and it stays 0, strobes included, while chip-enable stays high.
- R10: A strobe during a burst restarts it. `rd_valid` is 0 after the strobe edge, and the new burst follows R4 from the new start address.
- R11: Bit i of `rd_data` is bit (i mod ADDR_W) of `word_addr`, inverted when (i / ADDR_W) is odd. With the defaults this is {~word_addr, word_addr}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write command |
| cfg_sync_en | input | 1 | Burst mode enable field |
| cfg_mode | input | 2 | Address order field |
| cfg_wrap | input | 2 | Wrap block size field |
| cfg_latency | input | LAT_W | Initial latency in clock cycles |
| chip_en_n | input | 1 | Active-low chip enable |
| addr_strobe_n | input | 1 | Active-low start address valid |
| start_addr | input | ADDR_W | Burst start word address |
| rd_valid | output | 1 | Current word is valid |
| word_addr | output | ADDR_W | Current word address |
| rd_data | output | DATA_W | Word read from the internal array |

## Verification
The assertions assume three things about the inputs:
- Configuration writes do not land while a burst is streaming.
- Reset is applied for at least one edge before any traffic.
- The strobe is a single-cycle pulse inside a chip-enable window.

Under these assumptions, the burst-local order and the enable flag change only at edges where the checker's antecedents already exclude them. The directed tasks write the configuration only while chip-enable is high. They pulse the strobe for exactly one cycle, and they change every input at the falling edge.

// File: rtl/burst_pkg.sv
package burst_pkg;

   typedef enum logic [1:0] {
      ORD_LINEAR     = 2'b00,
      ORD_INTERLEAVE = 2'b01,
      ORD_CONT       = 2'b10,
      ORD_CONT_ALT   = 2'b11
   } burst_order_e;

   typedef enum logic [1:0] {
      SEQ_IDLE,
      SEQ_WAIT,
      SEQ_STREAM
   } seq_state_e;

   typedef struct packed {
      logic         sync_en;
      burst_order_e order;
      logic [1:0]   wrap_sel;
   } burst_cfg_t;

   function automatic logic is_continuous(burst_order_e o);
      return o[1];
   endfunction

endpackage

// File: rtl/burst_cfg_reg.sv
module burst_cfg_reg
   import burst_pkg::*;
#(
   parameter int LAT_W   = 4,
   parameter int DEF_LAT = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic             sync_en_in,
   input  logic [1:0]       order_in,
   input  logic [1:0]       wrap_in,
   input  logic [LAT_W-1:0] lat_in,
   output burst_cfg_t       cfg_o,
   output logic [LAT_W-1:0] lat_o
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_o.sync_en  <= 1'b0;
         cfg_o.order    <= ORD_LINEAR;
         cfg_o.wrap_sel <= 2'd0;
         lat_o          <= LAT_W'(DEF_LAT);
      end else if (we) begin
         cfg_o.sync_en  <= sync_en_in;
         cfg_o.order    <= burst_order_e'(order_in);
         cfg_o.wrap_sel <= wrap_in;
         lat_o          <= lat_in;
      end
   end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
   import burst_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic [ADDR_W-1:0] start,
   input  logic [ADDR_W-1:0] step,
   input  burst_order_e      order,
   input  logic [1:0]        wrap_sel,
   output logic [ADDR_W-1:0] addr
);

   localparam logic [ADDR_W-1:0] MIN_BLOCK = ADDR_W'(4);

   logic [ADDR_W-1:0] blk_mask;
   logic [ADDR_W-1:0] sum;

   always_comb begin
      blk_mask = (MIN_BLOCK << wrap_sel) - 1'b1;
      sum      = start + step;
      if (is_continuous(order))
         addr = sum;
      else if (order == ORD_INTERLEAVE)
         addr = (start & ~blk_mask) | ((start ^ step) & blk_mask);
      else
         addr = (start & ~blk_mask) | (sum & blk_mask);
   end

endmodule

// File: rtl/burst_word_array.sv
module burst_word_array #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] data
);

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      assign data[i] = addr[i % ADDR_W] ^ 1'((i / ADDR_W) % 2);
   end

endmodule

// File: rtl/burst_read_seq.sv
module burst_read_seq
   import burst_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int DATA_W  = 16,
   parameter int LAT_W   = 4,
   parameter int DEF_LAT = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_sync_en,
   input  logic [1:0]        cfg_mode,
   input  logic [1:0]        cfg_wrap,
   input  logic [LAT_W-1:0]  cfg_latency,
   input  logic              chip_en_n,
   input  logic              addr_strobe_n,
   input  logic [ADDR_W-1:0] start_addr,
   output logic              rd_valid,
   output logic [ADDR_W-1:0] word_addr,
   output logic [DATA_W-1:0] rd_data
);

   localparam int MAX_BLOCK_BITS = 5;

   if (ADDR_W < MAX_BLOCK_BITS) begin : g_addr_too_narrow
      $error("burst_read_seq: ADDR_W must hold a 32-word block");
   end
   if (LAT_W < 1 || DEF_LAT >= (1 << LAT_W)) begin : g_bad_latency
      $error("burst_read_seq: DEF_LAT does not fit LAT_W");
   end

   burst_cfg_t        cfg_q;
   logic [LAT_W-1:0]  lat_q;
   logic              sync_on;
   seq_state_e        state;
   logic [LAT_W-1:0]  wait_cnt;
   logic [ADDR_W-1:0] step_q;
   logic [ADDR_W-1:0] next_step;
   logic [ADDR_W-1:0] start_q;
   burst_order_e      order_q;
   logic [1:0]        wrap_q;
   logic [ADDR_W-1:0] gen_addr;

   burst_cfg_reg #(.LAT_W(LAT_W), .DEF_LAT(DEF_LAT)) u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .we         (cfg_we),
      .sync_en_in (cfg_sync_en),
      .order_in   (cfg_mode),
      .wrap_in    (cfg_wrap),
      .lat_in     (cfg_latency),
      .cfg_o      (cfg_q),
      .lat_o      (lat_q)
   );

   assign sync_on = cfg_q.sync_en;

   always_comb next_step = (state == SEQ_STREAM) ? step_q + 1'b1 : '0;

   burst_addr_gen #(.ADDR_W(ADDR_W)) u_gen (
      .start    (start_q),
      .step     (next_step),
      .order    (order_q),
      .wrap_sel (wrap_q),
      .addr     (gen_addr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= SEQ_IDLE;
         rd_valid  <= 1'b0;
         word_addr <= '0;
         wait_cnt  <= '0;
         step_q    <= '0;
         start_q   <= '0;
         order_q   <= ORD_LINEAR;
         wrap_q    <= 2'd0;
      end else if (chip_en_n || !sync_on) begin
         state    <= SEQ_IDLE;
         rd_valid <= 1'b0;
      end else if (!addr_strobe_n) begin
         state    <= SEQ_WAIT;
         rd_valid <= 1'b0;
         start_q  <= start_addr;
         order_q  <= cfg_q.order;
         wrap_q   <= cfg_q.wrap_sel;
         wait_cnt <= (lat_q == '0) ? LAT_W'(1) : lat_q;
      end else begin
         case (state)
            SEQ_WAIT: begin
               if (wait_cnt <= LAT_W'(1)) begin
                  state     <= SEQ_STREAM;
                  rd_valid  <= 1'b1;
                  step_q    <= next_step;
                  word_addr <= gen_addr;
               end else begin
                  wait_cnt <= wait_cnt - 1'b1;
               end
            end
            SEQ_STREAM: begin
               rd_valid  <= 1'b1;
               step_q    <= next_step;
               word_addr <= gen_addr;
            end
            default: rd_valid <= 1'b0;
         endcase
      end
   end

   burst_word_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
      .addr (word_addr),
      .data (rd_data)
   );

endmodule

// File: rtl/burst_read_seq_chk.sv
module burst_read_seq_chk
   import burst_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              chip_en_n,
   input logic              addr_strobe_n,
   input logic              sync_on,
   input burst_order_e      order_q,
   input logic [ADDR_W-1:0] start_q,
   input logic              rd_valid,
   input logic [ADDR_W-1:0] word_addr
);

   logic streaming;
   assign streaming = rd_valid && !chip_en_n && addr_strobe_n && sync_on;

   assert_async_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !sync_on |=> !rd_valid);

   assert_first_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_valid) |-> word_addr == start_q);

   assert_stream_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      streaming |=> rd_valid);

   assert_block_stay_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (streaming && !order_q[1]) |=>
         word_addr[ADDR_W-1:5] == $past(word_addr[ADDR_W-1:5]));

   assert_cont_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (streaming && order_q[1]) |=> word_addr == $past(word_addr) + 1'b1);

   assert_cs_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      chip_en_n |=> !rd_valid);

   assert_restart_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!chip_en_n && !addr_strobe_n) |=> !rd_valid);

endmodule

bind burst_read_seq burst_read_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .chip_en_n     (chip_en_n),
   .addr_strobe_n (addr_strobe_n),
   .sync_on       (sync_on),
   .order_q       (order_q),
   .start_q       (start_q),
   .rd_valid      (rd_valid),
   .word_addr     (word_addr)
);

// File: tb/burst_read_seq_test.sv
module burst_read_seq_test;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       cfg_we;
   logic       cfg_sync_en;
   logic [1:0] cfg_mode;
   logic [1:0] cfg_wrap;
   logic [3:0] cfg_latency;
   logic       chip_en_n;
   logic       addr_strobe_n;
   logic [7:0] start_addr;
   logic       rd_valid;
   logic [7:0] word_addr;
   logic [15:0] rd_data;

   int total = 0;
   int bad = 0;

   always #2.5 clk = ~clk;

   burst_read_seq uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .cfg_we        (cfg_we),
      .cfg_sync_en   (cfg_sync_en),
      .cfg_mode      (cfg_mode),
      .cfg_wrap      (cfg_wrap),
      .cfg_latency   (cfg_latency),
      .chip_en_n     (chip_en_n),
      .addr_strobe_n (addr_strobe_n),
      .start_addr    (start_addr),
      .rd_valid      (rd_valid),
      .word_addr     (word_addr),
      .rd_data       (rd_data)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   function automatic int exp_addr(int mode, int wrap, int start, int k);
      int blk  = 4 << wrap;
      int off  = start % blk;
      int base = start - off;
      if (mode >= 2) return (start + k) % 256;
      if (mode == 1) return base + (off ^ (k % blk));
      return base + ((off + k) % blk);
   endfunction

   task automatic set_cfg(input int sync, input int mode, input int wrap, input int lat);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sync_en = sync[0]; cfg_mode = mode[1:0];
      cfg_wrap = wrap[1:0]; cfg_latency = lat[3:0];
      tick();
      cfg_we = 1'b0;
   endtask

   task automatic strobe(input int start, input string req);
      @(negedge clk);
      chip_en_n = 1'b0; addr_strobe_n = 1'b0; start_addr = start[7:0];
      tick();
      addr_strobe_n = 1'b1;
      chk({req, " valid low on capture edge"}, int'(rd_valid), 0);
   endtask

   task automatic await_first(input int lat, input string req);
      int leff = (lat == 0) ? 1 : lat;
      for (int i = 1; i < leff; i++) begin
         tick();
         chk({req, " R4 latency gap"}, int'(rd_valid), 0);
      end
   endtask

   task automatic stream_words(input int mode, input int wrap, input int start,
                               input int n, input string req);
      for (int k = 0; k < n; k++) begin
         tick();
         chk({req, " R5 valid"}, int'(rd_valid), 1);
         chk({req, " addr"}, int'(word_addr), exp_addr(mode, wrap, start, k));
         chk("R11 data", int'(rd_data),
             ((~exp_addr(mode, wrap, start, k) & 255) << 8) | exp_addr(mode, wrap, start, k));
      end
   endtask

   task automatic end_burst();
      @(negedge clk);
      chip_en_n = 1'b1;
      tick();
      chk("R9 valid drops", int'(rd_valid), 0);
   endtask

   task automatic full_burst(input int mode, input int wrap, input int lat,
                             input int start, input int n, input string req);
      set_cfg(1, mode, wrap, lat);
      strobe(start, req);
      await_first(lat, req);
      stream_words(mode, wrap, start, n, req);
      end_burst();
   endtask

   task automatic test_reset();
      chk("R1 valid", int'(rd_valid), 0);
      chk("R1 addr", int'(word_addr), 0);
   endtask

   task automatic test_async_ignored();
      strobe(8'h33, "R2");
      for (int i = 0; i < 6; i++) begin
         tick();
         chk("R2 no burst while async", int'(rd_valid), 0);
      end
      end_burst();
   endtask

   task automatic test_default_latency();
      set_cfg(1, 0, 0, 2);
      strobe(8'h21, "R1");
      tick();
      chk("R1 default latency gap", int'(rd_valid), 0);
      tick();
      chk("R1 default latency first", int'(rd_valid), 1);
      chk("R1 first addr", int'(word_addr), 8'h21);
      end_burst();
   endtask

   task automatic test_cs_stop();
      set_cfg(1, 0, 1, 1);
      strobe(8'h40, "R9");
      stream_words(0, 1, 8'h40, 3, "R9");
      @(negedge clk);
      chip_en_n = 1'b1;
      tick();
      chk("R9 stop", int'(rd_valid), 0);
      @(negedge clk);
      addr_strobe_n = 1'b0;
      tick();
      addr_strobe_n = 1'b1;
      for (int i = 0; i < 4; i++) begin
         tick();
         chk("R9 stays idle", int'(rd_valid), 0);
      end
   endtask

   task automatic test_restart();
      set_cfg(1, 0, 1, 2);
      strobe(8'h10, "R10");
      await_first(2, "R10");
      stream_words(0, 1, 8'h10, 3, "R10");
      strobe(8'h87, "R10 restart");
      await_first(2, "R10");
      stream_words(0, 1, 8'h87, 5, "R10 new start");
      end_burst();
   endtask

   initial begin
      #(200000 * 5);
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; cfg_we = 1'b0; cfg_sync_en = 1'b0; cfg_mode = 2'd0;
      cfg_wrap = 2'd0; cfg_latency = 4'd0; chip_en_n = 1'b1;
      addr_strobe_n = 1'b1; start_addr = 8'h00;
      repeat (3) tick();
      test_reset();
      @(negedge clk);
      rst_n = 1'b1;
      tick();
      test_reset();
      test_async_ignored();
      test_default_latency();
      full_burst(0, 0, 3, 8'h4E, 10, "R3 R6 linear wrap4");
      full_burst(0, 3, 1, 8'h3B, 40, "R6 linear wrap32");
      full_burst(1, 1, 2, 8'h15, 12, "R7 interleave wrap8");
      full_burst(1, 2, 5, 8'h2C, 20, "R7 interleave wrap16");
      full_burst(2, 0, 4, 8'hFC, 8, "R8 continuous top wrap");
      full_burst(3, 1, 0, 8'h7E, 5, "R4 R8 latency zero");
      test_cs_stop();
      test_restart();
      set_cfg(0, 0, 0, 1);
      test_async_ignored();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule